// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block keeps the fault-confinement state of a CAN node. A bit-stream processor elsewhere in the controller reports transmit and receive errors and successes as command strobes. Each strobe carries a step size. The unit applies them to a transmit error counter and a receive error counter. From the counter values it works out the node's mode: error-active, error-passive or bus-off.

Once the transmit counter reaches the bus-off limit, the node goes bus-off. Both counters are cleared and further counter commands are ignored. The unit then watches the sampled bus bits and counts runs of eleven consecutive recessive bits. When the 128th run completes, the node returns to error-active by itself. If a recovery option input is set at that moment, the unit also raises a listen-only request, so the controller resumes without driving the bus.

The mode, both counters, a two-bit status flag and the listen-only request are registered outputs. Each one changes one clock after the edge that samples the inputs that caused the change.

Top module: `can_fault_conf`

## Requirements
- R1: After reset the mode is error-active (code 0), both counters read 0, `flags_o` is 2'b01 and `listen_only_o` is low.
- R2: Outside bus-off, a strobe adds or removes its step on the next clock. Increment and decrement of the same counter in one cycle are combined into a single net change. Neither counter goes below 0, and the receive counter saturates at 255.
- R3: Outside bus-off, the mode code is 1 (error-passive) when either counter is 128 or more, and 0 (error-active) when both are below 128. This includes falling back to error-active when both counters drop below 128.
- R4: When the transmit counter's next value would be 256 or more, the next mode is bus-off (code 2) and both counters read 0.
- R5: While bus-off, the counter command strobes have no effect: both counters stay at 0.
- R6: While bus-off, a bit with `bit_valid_i` high and `bit_recessive_i` high (1 = recessive) extends the current run. Eleven in a row make one completed run. A dominant valid bit restarts the current run but keeps the completed runs. Bits with `bit_valid_i` low are ignored. The cycle after the bit that completes the 128th run, the mode is error-active.
- R7: On leaving bus-off, `listen_only_o` takes the value of `cfg_listen_recover_i` sampled with the final recessive bit. It holds that value until the next bus-off entry clears it, or until reset.
- R8: `flags_o` bit 0 is high only in error-active, and bit 1 only in error-passive. Both bits are 0 while bus-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_listen_recover_i | input | 1 | Land in listen-only when leaving bus-off |
| tec_inc_i | input | 1 | Transmit counter increment strobe |
| tec_inc_step_i | input | 4 | Transmit increment amount |
| tec_dec_i | input | 1 | Transmit counter decrement strobe |
| tec_dec_step_i | input | 4 | Transmit decrement amount |
| rec_inc_i | input | 1 | Receive counter increment strobe |
| rec_inc_step_i | input | 4 | Receive increment amount |
| rec_dec_i | input | 1 | Receive counter decrement strobe |
| rec_dec_step_i | input | 4 | Receive decrement amount |
| bit_valid_i | input | 1 | A sampled bus bit is present this cycle |
| bit_recessive_i | input | 1 | Sampled bit value, 1 = recessive |
| mode_o | output | 2 | 0 active, 1 passive, 2 bus-off |
| tec_o | output | 9 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |
| flags_o | output | 2 | {passive, active} status |
| listen_only_o | output | 1 | Listen-only request after recovery |

## Verification
The bench steps the transmit counter exactly through 127, 128 and 255 and then onto 256. A design with an off-by-one threshold would report the wrong mode, or would go bus-off one step early or late. It drives the receive counter into its ceiling and both counters into the floor with large steps. A wrapping counter would show a small value where 255 or 0 belongs. It also issues increment and decrement in the same cycle, which catches logic that lets one strobe override the other. During recovery, the bench inserts a dominant bit midway through a run, invalid bits, and a check one bit before the final run completes. A tracker that lost its completed runs, counted invalid bits or exited one run early would leave bus-off at the wrong cycle. Recoveries with the option set and cleared show whether the listen-only request follows the option and is cleared on the next bus-off entry.

// File: rtl/fcu_pkg.sv
`timescale 1ns/1ps
package fcu_pkg;

  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_PASSIVE = 2'd1,
    FC_BUSOFF  = 2'd2
  } fc_mode_e;

  // Net counter step with floor at zero and ceiling at maxv.
  function automatic int fc_step(int cur, logic inc, int inc_amt,
                                 logic dec, int dec_amt, int maxv);
    int v;
    v = cur + (inc ? inc_amt : 0) - (dec ? dec_amt : 0);
    if (v < 0) v = 0;
    else if (v > maxv) v = maxv;
    return v;
  endfunction

  // Passive threshold test on a pair of counter values.
  function automatic logic fc_over(int tec, int rec, int lim);
    return (tec >= lim) || (rec >= lim);
  endfunction

endpackage

// File: rtl/fcu_err_counter.sv
`timescale 1ns/1ps
module fcu_err_counter #(
  parameter int W      = 9,
  parameter int STEP_W = 4,
  parameter int MAXV   = (1 << W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              hold_i,
  input  logic              inc_i,
  input  logic [STEP_W-1:0] inc_step_i,
  input  logic              dec_i,
  input  logic [STEP_W-1:0] dec_step_i,
  output logic [W-1:0]      count_o,
  output logic [W-1:0]      next_o
);
  import fcu_pkg::*;

  logic [W-1:0] count_q;
  int           nxt_i;

  always_comb begin
    nxt_i = fc_step(int'(count_q), inc_i, int'(inc_step_i),
                    dec_i, int'(dec_step_i), MAXV);
  end

  assign next_o = W'(nxt_i);

  always_ff @(posedge clk) begin
    if (!rst_n)       count_q <= '0;
    else if (clear_i) count_q <= '0;
    else if (!hold_i) count_q <= next_o;
  end

  assign count_o = count_q;
endmodule

// File: rtl/fcu_recovery.sv
`timescale 1ns/1ps
module fcu_recovery #(
  parameter int RUN_LEN    = 11,
  parameter int RUN_TARGET = 128
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          arm_i,
  input  logic                          bit_valid_i,
  input  logic                          bit_rec_i,
  output logic                          run_end_o,
  output logic                          done_o,
  output logic [$clog2(RUN_LEN)-1:0]    pos_o,
  output logic [$clog2(RUN_TARGET)-1:0] runs_o
);
  localparam int BW = $clog2(RUN_LEN);
  localparam int RW = $clog2(RUN_TARGET);

  logic [BW-1:0] bits_q;
  logic [RW-1:0] runs_q;
  logic          rec_bit;
  logic          dom_bit;

  assign rec_bit   = arm_i && bit_valid_i && bit_rec_i;
  assign dom_bit   = arm_i && bit_valid_i && !bit_rec_i;
  assign run_end_o = rec_bit && (bits_q == BW'(RUN_LEN - 1));
  assign done_o    = run_end_o && (runs_q == RW'(RUN_TARGET - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !arm_i) begin
      bits_q <= '0;
      runs_q <= '0;
    end else if (dom_bit) begin
      bits_q <= '0;
    end else if (run_end_o) begin
      bits_q <= '0;
      runs_q <= done_o ? '0 : runs_q + RW'(1);
    end else if (rec_bit) begin
      bits_q <= bits_q + BW'(1);
    end
  end

  assign pos_o  = bits_q;
  assign runs_o = runs_q;
endmodule

// File: rtl/fcu_mode.sv
`timescale 1ns/1ps
module fcu_mode #(
  parameter int TEC_W       = 9,
  parameter int REC_W       = 8,
  parameter int PASSIVE_LIM = 128,
  parameter int BUSOFF_LIM  = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TEC_W-1:0]     tec_next_i,
  input  logic [REC_W-1:0]     rec_next_i,
  input  logic                 recover_i,
  input  logic                 cfg_lo_i,
  output fcu_pkg::fc_mode_e    mode_o,
  output logic                 enter_busoff_o,
  output logic                 in_busoff_o,
  output logic                 listen_only_o,
  output logic [1:0]           flags_o
);
  import fcu_pkg::*;

  fc_mode_e mode_q;
  logic     lo_q;
  logic     passive_next;

  assign in_busoff_o    = (mode_q == FC_BUSOFF);
  assign enter_busoff_o = !in_busoff_o && (int'(tec_next_i) >= BUSOFF_LIM);
  assign passive_next   = fc_over(int'(tec_next_i), int'(rec_next_i), PASSIVE_LIM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= FC_ACTIVE;
      lo_q   <= 1'b0;
    end else begin
      case (mode_q)
        FC_BUSOFF: begin
          if (recover_i) begin
            mode_q <= FC_ACTIVE;
            lo_q   <= cfg_lo_i;
          end
        end
        FC_ACTIVE, FC_PASSIVE: begin
          if (enter_busoff_o) begin
            mode_q <= FC_BUSOFF;
            lo_q   <= 1'b0;
          end else begin
            mode_q <= passive_next ? FC_PASSIVE : FC_ACTIVE;
          end
        end
        default: mode_q <= FC_ACTIVE;
      endcase
    end
  end

  assign mode_o        = mode_q;
  assign listen_only_o = lo_q;
  assign flags_o       = {mode_q == FC_PASSIVE, mode_q == FC_ACTIVE};
endmodule

// File: rtl/can_fault_conf.sv
`timescale 1ns/1ps
module can_fault_conf #(
  parameter int TEC_W       = 9,
  parameter int REC_W       = 8,
  parameter int STEP_W      = 4,
  parameter int PASSIVE_LIM = 128,
  parameter int BUSOFF_LIM  = 256,
  parameter int RUN_LEN     = 11,
  parameter int RUN_TARGET  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_listen_recover_i,
  input  logic              tec_inc_i,
  input  logic [STEP_W-1:0] tec_inc_step_i,
  input  logic              tec_dec_i,
  input  logic [STEP_W-1:0] tec_dec_step_i,
  input  logic              rec_inc_i,
  input  logic [STEP_W-1:0] rec_inc_step_i,
  input  logic              rec_dec_i,
  input  logic [STEP_W-1:0] rec_dec_step_i,
  input  logic              bit_valid_i,
  input  logic              bit_recessive_i,
  output logic [1:0]        mode_o,
  output logic [TEC_W-1:0]  tec_o,
  output logic [REC_W-1:0]  rec_o,
  output logic [1:0]        flags_o,
  output logic              listen_only_o
);
  import fcu_pkg::*;

  localparam int TEC_MAX = (1 << TEC_W) - 1;
  localparam int REC_MAX = (1 << REC_W) - 1;
  localparam int PW      = $clog2(RUN_LEN);
  localparam int RW      = $clog2(RUN_TARGET);

  // Named internal events, visible to the bound checker.
  logic [TEC_W-1:0] tec_next;
  logic [REC_W-1:0] rec_next;
  logic             enter_busoff;
  logic             in_busoff;
  logic             run_end;
  logic             run_done;
  logic [PW-1:0]    run_pos;
  logic [RW-1:0]    runs_done;
  fc_mode_e         mode_e;

  fcu_err_counter #(.W(TEC_W), .STEP_W(STEP_W), .MAXV(TEC_MAX)) u_tec (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (enter_busoff),
    .hold_i     (in_busoff),
    .inc_i      (tec_inc_i),
    .inc_step_i (tec_inc_step_i),
    .dec_i      (tec_dec_i),
    .dec_step_i (tec_dec_step_i),
    .count_o    (tec_o),
    .next_o     (tec_next)
  );

  fcu_err_counter #(.W(REC_W), .STEP_W(STEP_W), .MAXV(REC_MAX)) u_rec (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (enter_busoff),
    .hold_i     (in_busoff),
    .inc_i      (rec_inc_i),
    .inc_step_i (rec_inc_step_i),
    .dec_i      (rec_dec_i),
    .dec_step_i (rec_dec_step_i),
    .count_o    (rec_o),
    .next_o     (rec_next)
  );

  fcu_recovery #(.RUN_LEN(RUN_LEN), .RUN_TARGET(RUN_TARGET)) u_recov (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm_i       (in_busoff),
    .bit_valid_i (bit_valid_i),
    .bit_rec_i   (bit_recessive_i),
    .run_end_o   (run_end),
    .done_o      (run_done),
    .pos_o       (run_pos),
    .runs_o      (runs_done)
  );

  fcu_mode #(
    .TEC_W(TEC_W), .REC_W(REC_W),
    .PASSIVE_LIM(PASSIVE_LIM), .BUSOFF_LIM(BUSOFF_LIM)
  ) u_mode (
    .clk            (clk),
    .rst_n          (rst_n),
    .tec_next_i     (tec_next),
    .rec_next_i     (rec_next),
    .recover_i      (run_done),
    .cfg_lo_i       (cfg_listen_recover_i),
    .mode_o         (mode_e),
    .enter_busoff_o (enter_busoff),
    .in_busoff_o    (in_busoff),
    .listen_only_o  (listen_only_o),
    .flags_o        (flags_o)
  );

  assign mode_o = mode_e;
endmodule

// File: rtl/fcu_checker.sv
`timescale 1ns/1ps
module fcu_checker #(
  parameter int TEC_W       = 9,
  parameter int REC_W       = 8,
  parameter int PASSIVE_LIM = 128,
  parameter int PW          = 4,
  parameter int RW          = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_lo,
  input logic             tec_inc,
  input logic             tec_dec,
  input logic             rec_inc,
  input logic             rec_dec,
  input logic             bit_valid,
  input logic             bit_rec,
  input logic [1:0]       mode,
  input logic [TEC_W-1:0] tec,
  input logic [REC_W-1:0] rec,
  input logic [1:0]       flags,
  input logic             lo,
  input logic             enter_busoff,
  input logic             in_busoff,
  input logic             run_end,
  input logic             run_done,
  input logic [PW-1:0]    run_pos,
  input logic [RW-1:0]    runs_done
);
  localparam logic [REC_W-1:0] REC_TOP = '1;

  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mode == 2'd0 && tec == '0 && rec == '0 && !lo));

  p_tec_still_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_busoff && !tec_inc && !tec_dec) |=> $stable(tec));

  p_rec_ceiling_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_busoff && !enter_busoff && rec == REC_TOP && rec_inc && !rec_dec) |=> rec == REC_TOP);

  p_active_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |-> (int'(tec) < PASSIVE_LIM && int'(rec) < PASSIVE_LIM));

  p_passive_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> (int'(tec) >= PASSIVE_LIM || int'(rec) >= PASSIVE_LIM));

  p_busoff_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    enter_busoff |=> (mode == 2'd2 && tec == '0 && rec == '0));

  p_busoff_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_busoff && !run_done) |=> (mode == 2'd2 && tec == '0 && rec == '0));

  p_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_done |=> mode == 2'd0);

  p_dominant_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_busoff && bit_valid && !bit_rec) |=> (run_pos == '0 && $stable(runs_done)));

  p_done_is_run_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_done |-> run_end);

  p_lo_on_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run_done |=> lo == $past(cfg_lo));

  p_lo_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    enter_busoff |=> !lo);

  p_flags_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flags) && ((flags == 2'b00) == (mode == 2'd2)));
endmodule

bind can_fault_conf fcu_checker #(
  .TEC_W(TEC_W), .REC_W(REC_W), .PASSIVE_LIM(PASSIVE_LIM),
  .PW($clog2(RUN_LEN)), .RW($clog2(RUN_TARGET))
) u_fcu_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_lo       (cfg_listen_recover_i),
  .tec_inc      (tec_inc_i),
  .tec_dec      (tec_dec_i),
  .rec_inc      (rec_inc_i),
  .rec_dec      (rec_dec_i),
  .bit_valid    (bit_valid_i),
  .bit_rec      (bit_recessive_i),
  .mode         (mode_o),
  .tec          (tec_o),
  .rec          (rec_o),
  .flags        (flags_o),
  .lo           (listen_only_o),
  .enter_busoff (enter_busoff),
  .in_busoff    (in_busoff),
  .run_end      (run_end),
  .run_done     (run_done),
  .run_pos      (run_pos),
  .runs_done    (runs_done)
);

// File: tb/tb_can_fault_conf.sv
`timescale 1ns/1ps
module tb_can_fault_conf;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg = 1'b0;
  logic       ti = 1'b0, td = 1'b0, ri = 1'b0, rd = 1'b0;
  logic [3:0] tis = '0, tds = '0, ris = '0, rds = '0;
  logic       bv = 1'b0, br = 1'b0;
  logic [1:0] mode_o;
  logic [8:0] tec_o;
  logic [7:0] rec_o;
  logic [1:0] flags_o;
  logic       lo_o;

  always #4 clk = ~clk;

  can_fault_conf dut (
    .clk(clk), .rst_n(rst_n), .cfg_listen_recover_i(cfg),
    .tec_inc_i(ti), .tec_inc_step_i(tis), .tec_dec_i(td), .tec_dec_step_i(tds),
    .rec_inc_i(ri), .rec_inc_step_i(ris), .rec_dec_i(rd), .rec_dec_step_i(rds),
    .bit_valid_i(bv), .bit_recessive_i(br),
    .mode_o(mode_o), .tec_o(tec_o), .rec_o(rec_o), .flags_o(flags_o),
    .listen_only_o(lo_o)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // Reference state kept by the bench.
  int m_mode = 0, m_tec = 0, m_rec = 0, m_bits = 0, m_runs = 0;
  bit m_lo = 0;

  function automatic int clampi(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  function automatic int exp_flags(int m);
    return (m == 0) ? 1 : ((m == 1) ? 2 : 0);
  endfunction

  task automatic model_tick();
    int t, r;
    if (m_mode != 2) begin
      t = clampi(m_tec + (ti ? int'(tis) : 0) - (td ? int'(tds) : 0), 0, 511);
      r = clampi(m_rec + (ri ? int'(ris) : 0) - (rd ? int'(rds) : 0), 0, 255);
      if (t >= 256) begin
        m_mode = 2; m_tec = 0; m_rec = 0; m_bits = 0; m_runs = 0; m_lo = 0;
      end else begin
        m_tec = t; m_rec = r;
        m_mode = (t >= 128 || r >= 128) ? 1 : 0;
      end
    end else if (bv) begin
      if (br) begin
        m_bits++;
        if (m_bits == 11) begin
          m_bits = 0;
          m_runs++;
          if (m_runs == 128) begin
            m_runs = 0; m_mode = 0; m_lo = cfg;
          end
        end
      end else begin
        m_bits = 0;
      end
    end
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "mode", int'(mode_o), m_mode);
    chk(tag, "tec", int'(tec_o), m_tec);
    chk(tag, "rec", int'(rec_o), m_rec);
    chk("R7", "listen_only", int'(lo_o), int'(m_lo));
    chk("R8", "flags", int'(flags_o), exp_flags(m_mode));
  endtask

  task automatic cycle(string tag);
    @(posedge clk);
    model_tick();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic cmd(string tag, bit a, int as, bit b, int bs, bit c, int cs, bit d, int ds);
    ti = a; tis = 4'(as); td = b; tds = 4'(bs);
    ri = c; ris = 4'(cs); rd = d; rds = 4'(ds);
    bv = 0; br = 0;
    cycle(tag);
    ti = 0; td = 0; ri = 0; rd = 0;
  endtask

  task automatic busbit(string tag, bit v, bit r);
    bv = v; br = r;
    cycle(tag);
    bv = 0; br = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    finished = 1;
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd90125));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1");               // reset state
    cycle("R1");

    // R2: receive counter ceiling and floor with large steps
    for (int i = 0; i < 20; i++) cmd("R2", 0, 0, 0, 0, 1, 15, 0, 0);
    chk("R2", "rec at ceiling", int'(rec_o), 255);
    cmd("R2", 0, 0, 0, 0, 1, 15, 0, 3);       // +15-3 at ceiling stays 255
    for (int i = 0; i < 20; i++) cmd("R3", 0, 0, 0, 0, 0, 0, 1, 15);
    chk("R2", "rec at floor", int'(rec_o), 0);
    cmd("R2", 0, 0, 1, 9, 0, 0, 1, 9);        // decrement at zero
    cmd("R2", 1, 8, 1, 1, 0, 0, 0, 0);        // combined +8-1 = 7

    // R3: transmit counter around the passive threshold
    for (int i = 0; i < 8; i++) cmd("R3", 1, 15, 0, 0, 0, 0, 0, 0);
    chk("R3", "tec below limit", int'(tec_o), 127);
    chk("R3", "active at 127", int'(mode_o), 0);
    cmd("R3", 1, 1, 0, 0, 0, 0, 0, 0);
    chk("R3", "passive at 128", int'(mode_o), 1);
    cmd("R3", 0, 0, 1, 1, 0, 0, 0, 0);
    chk("R3", "back to active", int'(mode_o), 0);

    // R4: climb to 255 then one more
    while (m_tec + 15 <= 255) cmd("R4", 1, 15, 0, 0, 0, 0, 0, 0);
    cmd("R4", 1, 255 - m_tec, 0, 0, 1, 5, 0, 0);
    chk("R4", "tec at 255", int'(tec_o), 255);
    chk("R4", "passive at 255", int'(mode_o), 1);
    cmd("R4", 1, 1, 0, 0, 0, 0, 0, 0);
    chk("R4", "bus-off at 256", int'(mode_o), 2);
    chk("R4", "rec cleared", int'(rec_o), 0);

    // R5: commands ignored while bus-off
    cmd("R5", 1, 15, 0, 0, 1, 15, 0, 0);
    cmd("R5", 0, 0, 1, 3, 0, 0, 1, 3);
    chk("R5", "tec held", int'(tec_o), 0);

    // R6 / R7: recovery with a broken run and ignored invalid bits
    cfg = 1;
    for (int i = 0; i < 10; i++) busbit("R6", 1, 1);
    busbit("R6", 1, 0);                       // dominant restarts run
    for (int i = 0; i < 5; i++) busbit("R6", 0, 0);
    for (int i = 0; i < 127 * 11; i++) busbit("R6", 1, 1);
    for (int i = 0; i < 10; i++) busbit("R6", 1, 1);
    chk("R6", "still bus-off one bit early", int'(mode_o), 2);
    busbit("R6", 1, 1);
    chk("R6", "active after last run", int'(mode_o), 0);
    chk("R7", "listen-only set", int'(lo_o), 1);

    // R7: next bus-off clears request; recovery with option off
    for (int i = 0; i < 18; i++) cmd("R4", 1, 15, 0, 0, 0, 0, 0, 0);
    chk("R7", "cleared on bus-off", int'(lo_o), 0);
    cfg = 0;
    for (int i = 0; i < 128 * 11; i++) busbit("R6", 1, 1);
    chk("R7", "listen-only stays low", int'(lo_o), 0);
    chk("R6", "active after option-off recovery", int'(mode_o), 0);

    // Mixed random stimulus
    for (int i = 0; i < 20000; i++) begin
      ti = ($urandom % 3) == 0; tis = 4'($urandom);
      td = ($urandom % 4) == 0; tds = 4'($urandom);
      ri = ($urandom % 3) == 0; ris = 4'($urandom);
      rd = ($urandom % 3) == 0; rds = 4'($urandom);
      if (m_mode == 2) begin
        bv = ($urandom % 8) != 0;
        br = ($urandom % 150) != 0;
      end else begin
        bv = $urandom % 2; br = $urandom % 2;
      end
      if (($urandom % 64) == 0) cfg = ~cfg;
      cycle((m_mode == 2) ? "R5" : "R2");
    end
    ti = 0; td = 0; ri = 0; rd = 0; bv = 0; br = 0;
    cycle("R3");
    finish_run();
  end
endmodule